// File: doc/BRIEF.md
# Masked Cart Interrupt Controller

This block merges four interrupt sources into a single active-high cart interrupt line. The four sources are a button press, a finished command, a USB receive FIFO that is not empty, and an incoming auxiliary data word. Each source keeps a sticky pending flag. The USB and auxiliary sources also have an enable mask that the host can change. The button and command sources are always enabled. The pending flags and masks appear as eight adjacent bits of a status word that the surrounding register file returns to the host.

The host controls the block through two word registers:

- **Interrupt control register.** It is write-only. Each of its bits either clears one pending flag or enables or disables one changeable mask. A bit written as 0 does nothing.
- **Auxiliary mailbox.** It holds a 32-bit word. A host write stores the word and sends a one-cycle strobe toward the USB side. A word arriving from the USB side replaces the stored word and raises the auxiliary pending flag. There is no flow control, so a newer word simply overwrites an older one.

A console reset pulse or a register-lock pulse clears every pending flag and disables every changeable mask. While special register access is off, the line stays low and host writes are ignored.

A three-state machine drives the line.

- **States:** IDLE (line low, nothing requested), ASSERTED (line high), and HOLD (line forced low for `LOW_HOLD` cycles after a de-assertion).
- **Transitions:**
  - *raise*: IDLE to ASSERTED, when a masked request exists and access is on.
  - *drop*: ASSERTED to HOLD, when the request vanishes or access goes off.
  - *hold-count*: HOLD to HOLD, while the hold counter is non-zero.
  - *re-raise*: HOLD to ASSERTED, when the counter has expired and a request exists.
  - *settle*: HOLD to IDLE, when the counter has expired and no request exists.

Because of the HOLD state, every new interrupt reaches the console as a distinct rising edge.

Top module: `cart_irq_hub`

## Requirements
- R1: After the asynchronous active-low reset, the following hold: all pending flags are 0, both changeable masks are 0, `cart_irq` is 0, the mailbox word is 0 and `aux_tx_valid` is 0.
- R2: `status_word` carries these bits:
  - bit 29: button pending; bit 28: button mask
  - bit 27: command pending; bit 26: command mask
  - bit 25: USB pending; bit 24: USB mask
  - bit 23: AUX pending; bit 22: AUX mask

  Bits 28 and 26 always read 1, and every other bit reads 0. After reset the word is 32'h1400_0000.
- R3: An event pulse on `btn_evt`, `cmd_done_evt` or `usb_rx_evt` sets its pending flag at the next clock edge. The flag stays set until it is cleared.
- R4: A host write to offset 5'h14 clears pending flags. A 1 in data bit 31 clears button, bit 30 clears command, bit 29 clears USB and bit 28 clears AUX. Zero bits leave their flag unchanged.
- R5: When a clear and a set event for the same source fall in the same cycle, the flag ends up set.
- R6: In a write to offset 5'h14, data bit 10 enables the USB mask and bit 11 disables it. Bit 8 enables the AUX mask and bit 9 disables it. If both bits of a pair are 1, the mask is disabled.
- R7: A `nmi_pulse` or `lock_pulse` clears all pending flags and both changeable masks at the next edge. This takes priority over any event or host write in the same cycle.
- R8: `cart_irq` rises one clock after any source has both its pending flag and its mask at 1. That is two edges after the event pulse.
- R9: After `cart_irq` falls, it stays low for at least `LOW_HOLD` cycles (default 2) before it can rise again.
- R10: While `access_en` is 0, `cart_irq` is 0 within the same cycle. Host writes to either register have no effect during that time.
- R11: A host write to offset 5'h18 stores the data word as the mailbox value. In the next cycle it also raises `aux_tx_valid` for exactly one cycle, with `aux_tx_data` equal to the written word.
- R12: A `usb_aux_valid` pulse stores `usb_aux_data` as the mailbox value and sets the AUX pending flag. It wins over a host mailbox write in the same cycle, while that host word is still sent on `aux_tx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| access_en | input | 1 | Special register access enabled |
| nmi_pulse | input | 1 | Console reset event, one cycle |
| lock_pulse | input | 1 | Register lock event, one cycle |
| btn_evt | input | 1 | Button pressed event |
| cmd_done_evt | input | 1 | Command finished with interrupt requested |
| usb_rx_evt | input | 1 | USB receive data present |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | ADDR_W | Host write byte offset |
| host_wr_data | input | 32 | Host write data |
| usb_aux_valid | input | 1 | Incoming mailbox word strobe from USB side |
| usb_aux_data | input | 32 | Incoming mailbox word |
| status_word | output | 32 | Pending and mask bits for the status register |
| aux_rd_data | output | 32 | Current mailbox word |
| aux_tx_valid | output | 1 | Outgoing mailbox word strobe |
| aux_tx_data | output | 32 | Outgoing mailbox word |
| cart_irq | output | 1 | Cart interrupt line, active high |

## Verification
The following properties are checked on every cycle:

- A lock or console reset pulse leaves all eight flag bits in their cleared pattern.
- A button event always wins over a clear.
- The line never rises without a masked request registered one cycle earlier.
- The line is low whenever access is off.
- Every outgoing strobe follows an accepted host mailbox write.
- Incoming USB words land in the mailbox.
- A counter confirms the low time before each re-rise.

The following behaviours can only be shown by the bench's scenarios:

- The exact rise latency.
- That zero bits and locked writes change nothing.
- That disable wins over enable.
- That the HOLD state delays a request which reappears right after a drop.

// File: rtl/cirq_pkg.sv
`timescale 1ns/1ps
package cirq_pkg;

    localparam int SRC_N  = 4;
    localparam int WORD_W = 32;

    localparam int SRC_BTN = 0;
    localparam int SRC_CMD = 1;
    localparam int SRC_USB = 2;
    localparam int SRC_AUX = 3;

    // Status layout: pending at FLAG_TOP-2*i, mask directly below it.
    localparam int FLAG_TOP = 29;
    // Clear bits: source i is cleared by bit CLR_TOP-i.
    localparam int CLR_TOP  = 31;

    // Masks that can never be changed (button, command).
    localparam logic [SRC_N-1:0] FIXED_MASK = 4'b0011;

    typedef enum logic [1:0] {
        LINE_IDLE   = 2'd0,
        LINE_ASSERT = 2'd1,
        LINE_HOLD   = 2'd2
    } line_state_e;

endpackage

// File: rtl/cirq_regdec.sv
`timescale 1ns/1ps
module cirq_regdec
    import cirq_pkg::*;
#(
    parameter int               ADDR_W  = 5,
    parameter logic [ADDR_W-1:0] IRQ_OFS = 5'h14,
    parameter logic [ADDR_W-1:0] AUX_OFS = 5'h18
) (
    input  logic              wr_en,
    input  logic              access_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        clr_field,   // data bits 31..28
    input  logic [3:0]        ctl_field,   // data bits 11..8
    output logic [SRC_N-1:0]  clr_vec,
    output logic [SRC_N-1:0]  en_vec,
    output logic [SRC_N-1:0]  dis_vec,
    output logic              aux_wr
);

    logic wr_ok;
    logic irq_hit;

    always_comb begin
        wr_ok   = wr_en && access_en;
        irq_hit = wr_ok && (wr_addr == IRQ_OFS);
        aux_wr  = wr_ok && (wr_addr == AUX_OFS);
    end

    // Clear field: field bit 3 (data 31) maps to source 0 and so on.
    always_comb begin
        for (int i = 0; i < SRC_N; i++) begin
            clr_vec[i] = irq_hit && clr_field[(CLR_TOP - 28) - i];
        end
    end

    // Control field: [3] USB off, [2] USB on, [1] AUX off, [0] AUX on.
    always_comb begin
        en_vec  = '0;
        dis_vec = '0;
        en_vec[SRC_USB]  = irq_hit && ctl_field[2];
        dis_vec[SRC_USB] = irq_hit && ctl_field[3];
        en_vec[SRC_AUX]  = irq_hit && ctl_field[0];
        dis_vec[SRC_AUX] = irq_hit && ctl_field[1];
    end

endmodule

// File: rtl/cirq_pending.sv
`timescale 1ns/1ps
module cirq_pending
    import cirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [SRC_N-1:0] set_vec,
    input  logic [SRC_N-1:0] clr_vec,
    input  logic [SRC_N-1:0] en_vec,
    input  logic [SRC_N-1:0] dis_vec,
    output logic [SRC_N-1:0] pend,
    output logic [SRC_N-1:0] mask,
    output logic             req
);

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        // Pending flag: global clear first, then set beats clear.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (clr_all) begin
                pend[i] <= 1'b0;
            end else if (set_vec[i]) begin
                pend[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                pend[i] <= 1'b0;
            end
        end

        // Mask: fixed sources return to 1, changeable ones to 0.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[i] <= FIXED_MASK[i];
            end else if (clr_all) begin
                mask[i] <= FIXED_MASK[i];
            end else if (dis_vec[i] && !FIXED_MASK[i]) begin
                mask[i] <= 1'b0;
            end else if (en_vec[i]) begin
                mask[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        req = |(pend & mask);
    end

endmodule

// File: rtl/cirq_aux_mailbox.sv
`timescale 1ns/1ps
module cirq_aux_mailbox
    import cirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_data,
    input  logic              usb_valid,
    input  logic [WORD_W-1:0] usb_data,
    output logic [WORD_W-1:0] word_q,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data
);

    // Incoming USB word wins the shared storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (usb_valid) begin
            word_q <= usb_data;
        end else if (host_wr) begin
            word_q <= host_data;
        end
    end

    // The outgoing path always carries the host word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= host_wr;
            if (host_wr) begin
                tx_data <= host_data;
            end
        end
    end

endmodule

// File: rtl/cirq_line_fsm.sv
`timescale 1ns/1ps
module cirq_line_fsm
    import cirq_pkg::*;
#(
    parameter int LOW_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic access_en,
    output logic line_out
);

    localparam int              CNT_W     = (LOW_HOLD < 2) ? 1 : $clog2(LOW_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(LOW_HOLD - 1);

    line_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LINE_IDLE: begin
                if (req && access_en) begin          // raise
                    state_d = LINE_ASSERT;
                end
            end
            LINE_ASSERT: begin
                if (!req || !access_en) begin        // drop
                    state_d = LINE_HOLD;
                    cnt_d   = HOLD_LOAD;
                end
            end
            LINE_HOLD: begin
                if (cnt_q != '0) begin               // hold-count
                    cnt_d = cnt_q - 1'b1;
                end else if (req && access_en) begin // re-raise
                    state_d = LINE_ASSERT;
                end else begin                       // settle
                    state_d = LINE_IDLE;
                end
            end
            default: begin
                state_d = LINE_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        line_out = (state_q == LINE_ASSERT) && access_en;
    end

endmodule

// File: rtl/cart_irq_hub.sv
`timescale 1ns/1ps
module cart_irq_hub
    import cirq_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] IRQ_OFS  = 5'h14,
    parameter logic [ADDR_W-1:0] AUX_OFS  = 5'h18,
    parameter int                LOW_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access_en,
    input  logic              nmi_pulse,
    input  logic              lock_pulse,
    input  logic              btn_evt,
    input  logic              cmd_done_evt,
    input  logic              usb_rx_evt,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [31:0]       host_wr_data,
    input  logic              usb_aux_valid,
    input  logic [31:0]       usb_aux_data,
    output logic [31:0]       status_word,
    output logic [31:0]       aux_rd_data,
    output logic              aux_tx_valid,
    output logic [31:0]       aux_tx_data,
    output logic              cart_irq
);

    logic [SRC_N-1:0] clr_vec, en_vec, dis_vec, set_vec, pend, mask;
    logic             aux_wr, req, clr_all;

    always_comb begin
        clr_all          = nmi_pulse || lock_pulse;
        set_vec          = '0;
        set_vec[SRC_BTN] = btn_evt;
        set_vec[SRC_CMD] = cmd_done_evt;
        set_vec[SRC_USB] = usb_rx_evt;
        set_vec[SRC_AUX] = usb_aux_valid;
    end

    cirq_regdec #(
        .ADDR_W (ADDR_W),
        .IRQ_OFS(IRQ_OFS),
        .AUX_OFS(AUX_OFS)
    ) u_dec (
        .wr_en    (host_wr_en),
        .access_en(access_en),
        .wr_addr  (host_wr_addr),
        .clr_field(host_wr_data[31:28]),
        .ctl_field(host_wr_data[11:8]),
        .clr_vec  (clr_vec),
        .en_vec   (en_vec),
        .dis_vec  (dis_vec),
        .aux_wr   (aux_wr)
    );

    cirq_pending u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_all(clr_all),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .en_vec (en_vec),
        .dis_vec(dis_vec),
        .pend   (pend),
        .mask   (mask),
        .req    (req)
    );

    cirq_aux_mailbox u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (aux_wr),
        .host_data(host_wr_data),
        .usb_valid(usb_aux_valid),
        .usb_data (usb_aux_data),
        .word_q   (aux_rd_data),
        .tx_valid (aux_tx_valid),
        .tx_data  (aux_tx_data)
    );

    cirq_line_fsm #(
        .LOW_HOLD(LOW_HOLD)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .access_en(access_en),
        .line_out (cart_irq)
    );

    always_comb begin
        status_word = '0;
        for (int i = 0; i < SRC_N; i++) begin
            status_word[FLAG_TOP - 2*i]     = pend[i];
            status_word[FLAG_TOP - 2*i - 1] = mask[i];
        end
    end

endmodule

// File: rtl/cirq_checker.sv
`timescale 1ns/1ps
module cirq_checker #(
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] AUX_OFS  = 5'h18,
    parameter int                LOW_HOLD = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              access_en,
    input logic              nmi_pulse,
    input logic              lock_pulse,
    input logic              btn_evt,
    input logic              host_wr_en,
    input logic [ADDR_W-1:0] host_wr_addr,
    input logic              usb_aux_valid,
    input logic [31:0]       usb_aux_data,
    input logic [7:0]        flags,
    input logic [31:0]       aux_rd_data,
    input logic              aux_tx_valid,
    input logic              cart_irq
);

    logic       masked_req;
    logic [7:0] low_cnt;
    logic       seen_high;

    always_comb begin
        masked_req = (flags[7] & flags[6]) | (flags[5] & flags[4]) |
                     (flags[3] & flags[2]) | (flags[1] & flags[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            seen_high <= 1'b0;
        end else if (cart_irq) begin
            low_cnt   <= '0;
            seen_high <= 1'b1;
        end else if (low_cnt != 8'hFF) begin
            low_cnt <= low_cnt + 8'd1;
        end
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_evt && !nmi_pulse && !lock_pulse) |=> flags[7]);

    p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pulse || lock_pulse) |=> (flags == 8'b0101_0000));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cart_irq |-> $past(masked_req));

    p_low_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cart_irq) && seen_high) |-> (low_cnt >= 8'(LOW_HOLD)));

    p_quiet_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !access_en |-> !cart_irq);

    p_tx_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        aux_tx_valid |-> $past(host_wr_en && access_en && (host_wr_addr == AUX_OFS)));

    p_usb_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        usb_aux_valid |=> (aux_rd_data == $past(usb_aux_data)));

endmodule

bind cart_irq_hub cirq_checker #(
    .ADDR_W  (ADDR_W),
    .AUX_OFS (AUX_OFS),
    .LOW_HOLD(LOW_HOLD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .access_en    (access_en),
    .nmi_pulse    (nmi_pulse),
    .lock_pulse   (lock_pulse),
    .btn_evt      (btn_evt),
    .host_wr_en   (host_wr_en),
    .host_wr_addr (host_wr_addr),
    .usb_aux_valid(usb_aux_valid),
    .usb_aux_data (usb_aux_data),
    .flags        (status_word[29:22]),
    .aux_rd_data  (aux_rd_data),
    .aux_tx_valid (aux_tx_valid),
    .cart_irq     (cart_irq)
);

// File: tb/sim_cart_irq_hub.sv
`timescale 1ns/1ps
module sim_cart_irq_hub;

    localparam int LOW_HOLD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        access_en = 1'b0;
    logic        nmi_pulse = 1'b0, lock_pulse = 1'b0;
    logic        btn_evt = 1'b0, cmd_done_evt = 1'b0, usb_rx_evt = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [4:0]  host_wr_addr = '0;
    logic [31:0] host_wr_data = '0;
    logic        usb_aux_valid = 1'b0;
    logic [31:0] usb_aux_data = '0;
    logic [31:0] status_word, aux_rd_data, aux_tx_data;
    logic        aux_tx_valid, cart_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Model state
    logic [3:0]  m_pend;
    logic        m_musb, m_maux, m_txv, m_on, m_hold;
    logic [31:0] m_aux, m_txd;
    int          m_cnt;

    always #10 clk = ~clk;

    cart_irq_hub #(.LOW_HOLD(LOW_HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .access_en(access_en),
        .nmi_pulse(nmi_pulse), .lock_pulse(lock_pulse),
        .btn_evt(btn_evt), .cmd_done_evt(cmd_done_evt), .usb_rx_evt(usb_rx_evt),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .usb_aux_valid(usb_aux_valid), .usb_aux_data(usb_aux_data),
        .status_word(status_word), .aux_rd_data(aux_rd_data),
        .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data), .cart_irq(cart_irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[29] = m_pend[0]; s[28] = 1'b1;
        s[27] = m_pend[1]; s[26] = 1'b1;
        s[25] = m_pend[2]; s[24] = m_musb;
        s[23] = m_pend[3]; s[22] = m_maux;
        return s;
    endfunction

    task automatic model_reset();
        m_pend = '0; m_musb = 0; m_maux = 0; m_txv = 0; m_on = 0; m_hold = 0;
        m_aux = '0; m_txd = '0; m_cnt = 0;
    endtask

    task automatic model_edge();
        logic req, wr_ok, irq_hit, aux_hit;
        logic [3:0] setv, clrv;
        req = |(m_pend & {m_maux, m_musb, 2'b11});
        // Line per R8 R9 R10
        if (m_on) begin
            if (!req || !access_en) begin m_on = 0; m_hold = 1; m_cnt = LOW_HOLD - 1; end
        end else if (m_hold) begin
            if (m_cnt != 0) m_cnt--;
            else begin m_hold = 0; if (req && access_en) m_on = 1; end
        end else if (req && access_en) begin
            m_on = 1;
        end
        wr_ok   = host_wr_en && access_en;
        irq_hit = wr_ok && (host_wr_addr == 5'h14);
        aux_hit = wr_ok && (host_wr_addr == 5'h18);
        if (nmi_pulse || lock_pulse) begin
            m_pend = '0; m_musb = 0; m_maux = 0;
        end else begin
            setv = {usb_aux_valid, usb_rx_evt, cmd_done_evt, btn_evt};
            clrv = irq_hit ? {host_wr_data[28], host_wr_data[29], host_wr_data[30], host_wr_data[31]} : 4'b0;
            m_pend = setv | (m_pend & ~clrv);
            if (irq_hit) begin
                if (host_wr_data[11]) m_musb = 0; else if (host_wr_data[10]) m_musb = 1;
                if (host_wr_data[9])  m_maux = 0; else if (host_wr_data[8])  m_maux = 1;
            end
        end
        if (usb_aux_valid) m_aux = usb_aux_data;
        else if (aux_hit)  m_aux = host_wr_data;
        m_txv = aux_hit;
        if (aux_hit) m_txd = host_wr_data;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(status_word, exp_status(), "R3 R4 R6 status");
        chk({31'b0, cart_irq}, {31'b0, m_on && access_en}, "R8 R9 R10 line");
        chk(aux_rd_data, m_aux, "R11 R12 mailbox");
        chk({31'b0, aux_tx_valid}, {31'b0, m_txv}, "R11 strobe");
        if (m_txv) chk(aux_tx_data, m_txd, "R11 tx word");
        btn_evt = 0; cmd_done_evt = 0; usb_rx_evt = 0;
        nmi_pulse = 0; lock_pulse = 0; host_wr_en = 0; usb_aux_valid = 0;
    endtask

    task automatic host_set(input logic [4:0] a, input logic [31:0] d);
        host_wr_en = 1; host_wr_addr = a; host_wr_data = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_val;
        seed_val = $urandom(32'h5EED_0042);
        access_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        // R1 R2: reset state
        chk(status_word, 32'h1400_0000, "R1 R2 reset status");
        chk({31'b0, cart_irq}, 32'd0, "R1 line");
        chk(aux_rd_data, 32'd0, "R1 mailbox");
        chk({31'b0, aux_tx_valid}, 32'd0, "R1 strobe");

        // R3 and R8 latency
        btn_evt = 1; tick();
        chk({31'b0, status_word[29]}, 32'd1, "R3 button pending");
        chk({31'b0, cart_irq}, 32'd0, "R8 not yet");
        tick();
        chk({31'b0, cart_irq}, 32'd1, "R8 raised");

        // R4 zero bits: no effect
        host_set(5'h14, 32'h0000_0000); tick();
        chk({31'b0, status_word[29]}, 32'd1, "R4 zero write");

        // R5: clear and set together
        host_set(5'h14, 32'h8000_0000); btn_evt = 1; tick();
        chk({31'b0, status_word[29]}, 32'd1, "R5 set wins");

        // R4 clear, then R9 hold with immediate re-request
        host_set(5'h14, 32'h8000_0000); tick();
        chk({31'b0, status_word[29]}, 32'd0, "R4 cleared");
        btn_evt = 1; tick();
        chk({31'b0, cart_irq}, 32'd0, "R9 dropped");
        tick();
        chk({31'b0, cart_irq}, 32'd0, "R9 still held low");
        tick();
        chk({31'b0, cart_irq}, 32'd1, "R9 re-raised");

        // R6 masks
        host_set(5'h14, 32'h0000_0400); tick();
        chk({31'b0, status_word[24]}, 32'd1, "R6 usb enable");
        host_set(5'h14, 32'h0000_0C00); tick();
        chk({31'b0, status_word[24]}, 32'd0, "R6 disable wins");
        host_set(5'h14, 32'h0000_0100); tick();
        chk({31'b0, status_word[22]}, 32'd1, "R6 aux enable");
        host_set(5'h14, 32'h0000_0200); tick();
        chk({31'b0, status_word[22]}, 32'd0, "R6 aux disable");

        // R10: access off
        access_en = 0; #1;
        chk({31'b0, cart_irq}, 32'd0, "R10 line forced low");
        host_set(5'h14, 32'h8000_0400); tick();
        chk({31'b0, status_word[24]}, 32'd0, "R10 mask write ignored");
        chk({31'b0, status_word[29]}, 32'd1, "R10 clear ignored");
        host_set(5'h18, 32'h0BAD_F00D); tick();
        tick();
        chk(aux_rd_data, 32'd0, "R10 mailbox write ignored");
        access_en = 1; tick(); tick();

        // R11 host mailbox write
        host_set(5'h18, 32'hA5A5_0F0F); tick();
        chk({31'b0, aux_tx_valid}, 32'd1, "R11 strobe up");
        chk(aux_tx_data, 32'hA5A5_0F0F, "R11 tx word");
        chk(aux_rd_data, 32'hA5A5_0F0F, "R11 stored");
        tick();
        chk({31'b0, aux_tx_valid}, 32'd0, "R11 one cycle");

        // R12 incoming word beats host write
        usb_aux_valid = 1; usb_aux_data = 32'h1234_5678;
        host_set(5'h18, 32'hDEAD_BEEF); tick();
        chk(aux_rd_data, 32'h1234_5678, "R12 usb wins");
        chk({31'b0, status_word[23]}, 32'd1, "R12 aux pending");
        chk(aux_tx_data, 32'hDEAD_BEEF, "R12 host word sent");

        // R7 global clears
        host_set(5'h14, 32'h0000_0500); usb_rx_evt = 1; tick();
        nmi_pulse = 1; btn_evt = 1; tick();
        chk(status_word, 32'h1400_0000, "R7 nmi clear");
        host_set(5'h14, 32'h0000_0500); cmd_done_evt = 1; tick();
        lock_pulse = 1; usb_aux_valid = 1; usb_aux_data = 32'h0000_0077; tick();
        chk(status_word, 32'h1400_0000, "R7 lock clear");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            btn_evt       = (r[3:0] == 4'd0);
            cmd_done_evt  = (r[7:4] == 4'd1);
            usb_rx_evt    = (r[11:8] == 4'd2);
            usb_aux_valid = (r[15:12] == 4'd3);
            usb_aux_data  = $urandom;
            nmi_pulse     = (r[23:16] == 8'd7);
            lock_pulse    = (r[31:24] == 8'd9);
            access_en     = ($urandom % 40) != 0;
            if ((r[19:17] == 3'd0) || (r[27:25] == 3'd1)) begin
                logic [31:0] a;
                a = $urandom % 4;
                host_set((a == 0) ? 5'h14 : (a == 1) ? 5'h18 : (a == 2) ? 5'h00 : 5'h14,
                         $urandom);
            end
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule